// File: doc/BRIEF.md
# Dual-Register Sum-of-Products Output Cell

This block models one output cell of a sum-of-products programmable logic device. It takes twelve data product terms in three groups of four and ORs each group into a partial sum. An 8-bit configuration word decides how many partial sums reach the first register or the pad, how both registers update, and which signals go back to the global logic array. Five more product terms supply a clear and a clock for each register and the pad output enable. A group-wide synchronous preset, a dedicated pin clock, the pad input and a test preload complete the inputs.

Everything runs on one system clock. Each cell clock (a product term, optionally ANDed with the pin clock) goes through a rising-edge detector, and the detected edge acts as the update enable of its register. The cell drives the pad value, the pad enable and six feedback bits for the surrounding array.

Top module: `plm_macrocell`

## Requirements
- R1: While `rst_n` is low, both registers are held at 0, so `fb_o[3]`=0 and `fb_o[2]`=1 after reset.
- R2: With `cfg_i[2]`=0 the pad takes register 1. The register 1 input is group0|group1 for `cfg_i[1:0]` of 00, 01 and 11, and group0|group1|group2 for 10. The register 2 input is always group2. Group g is `pt_sum_i[4g+3:4g]` ORed.
- R3: With `cfg_i[2]`=1 the pad takes the combinational sum: group0|group1 for 00, group0 for 01, all three groups for 10, and for 11 group0|group1 if `cfg_i[5]`=1, else group0. Register 1 loads the same sum.
- R4: `fb_o[5]` is F2 and `fb_o[4]` its complement. F2 is the register 2 input for `cfg_i[2:0]`=011, for `cfg_i[2:0]`=111, and for `cfg_i[2:0]`=101 when `cfg_i[5]`=1. Otherwise F2 is Q2.
- R5: `cfg_i[3]`=1 drives the pad value true, and 0 drives it inverted.
- R6: `cfg_i[4]`=1 makes register 1 toggle-type, and `cfg_i[5]`=1 does the same for register 2, but only while `cfg_i[2]`=0. A toggle register inverts when its input is 1 and holds when its input is 0. A data register loads its input.
- R7: A register updates only in the cycle in which its clock source rises, as seen at a system clock edge. The clock source is the clock product term alone when `cfg_i[6]` (register 1) or `cfg_i[7]` (register 2) is 0, and that term ANDed with `pin_clk_i` when the bit is 1.
- R8: A high clear term (`pt_clr1_i`, `pt_clr2_i`) zeroes its register at the next system edge, with or without a clock edge, and wins over preset and update.
- R9: `grp_preset_i` high on a register's clock edge sets that register to 1 in place of its normal update, unless its clear term is high.
- R10: While `preload_en_i` is high, register 1 loads `preload_val_i[0]` and register 2 loads `preload_val_i[1]` at each system edge, overriding clear, preset and update.
- R11: `oe_o` follows `pt_oe_i`. `fb_o[3:0]` is {Q1, ~Q1, `pad_i`, ~`pad_i`}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up clear |
| pt_sum_i | input | 12 | Data product terms, three groups of four |
| pt_clr1_i | input | 1 | Register 1 clear term |
| pt_clk1_i | input | 1 | Register 1 clock term |
| pt_clk2_i | input | 1 | Register 2 clock term |
| pt_clr2_i | input | 1 | Register 2 clear term |
| pt_oe_i | input | 1 | Output enable term |
| grp_preset_i | input | 1 | Group-shared synchronous preset |
| pin_clk_i | input | 1 | Dedicated pin clock |
| pad_i | input | 1 | Pad input value |
| cfg_i | input | 8 | Configuration word |
| preload_en_i | input | 1 | Test preload enable |
| preload_val_i | input | 2 | Preload values, bit0 register 1, bit1 register 2 |
| pad_o | output | 1 | Pad output value |
| oe_o | output | 1 | Pad output enable |
| fb_o | output | 6 | Feedback bits to the array |

## Verification
The assertions check on every cycle how register 1 settles: preload capture for both registers, the clear term winning, no change without a clock-source rise, preset on a rise, and hold of a toggle register when its input is 0. The steering of every configuration word, output polarity, the feedback selection and the interplay of the pin clock gating with random clock terms can only be shown by the bench's scenarios. The bench sweeps all 256 configuration words under random terms against its own reference model and adds directed sequences for toggling, gating, clear, preset and preload.

// File: rtl/plm_pkg.sv
package plm_pkg;
    localparam int NUM_GRP = 3;
    localparam int NUM_REG = 2;

    typedef struct packed {
        logic clk2_pin;   // bit 7
        logic clk1_pin;   // bit 6
        logic r2_toggle;  // bit 5
        logic r1_toggle;  // bit 4
        logic act_high;   // bit 3
        logic comb_out;   // bit 2
        logic sel_hi;     // bit 1
        logic sel_lo;     // bit 0
    } cfg_t;

    typedef struct packed {
        logic q;
        logic prev;
    } flop_st_t;
endpackage

// File: rtl/plm_steer.sv
module plm_steer
    import plm_pkg::*;
#(
    parameter int GRP_W = 4,
    localparam int PT_W = NUM_GRP * GRP_W
) (
    input  logic [PT_W-1:0] pt_i,
    input  cfg_t            cfg_i,
    output logic            dt1_o,
    output logic            dt2_o,
    output logic            comb_o,
    output logic            fb_dt2_o,
    output logic            r2_tog_o
);
    logic [NUM_GRP-1:0] grp;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        assign grp[g] = |pt_i[g*GRP_W +: GRP_W];
    end

    logic s4, s8, s12;
    assign s4  = grp[0];
    assign s8  = grp[0] | grp[1];
    assign s12 = s8 | grp[2];

    always_comb begin
        dt2_o    = grp[2];
        dt1_o    = s8;
        comb_o   = s8;
        fb_dt2_o = 1'b0;
        r2_tog_o = 1'b0;
        if (!cfg_i.comb_out) begin
            r2_tog_o = cfg_i.r2_toggle;
            case ({cfg_i.sel_hi, cfg_i.sel_lo})
                2'b10:   dt1_o = s12;
                2'b11:   fb_dt2_o = 1'b1;
                default: dt1_o = s8;
            endcase
            comb_o = dt1_o;
        end else begin
            case ({cfg_i.sel_hi, cfg_i.sel_lo})
                2'b00: comb_o = s8;
                2'b01: begin
                    comb_o   = s4;
                    fb_dt2_o = cfg_i.r2_toggle;
                end
                2'b10: comb_o = s12;
                default: begin
                    comb_o   = cfg_i.r2_toggle ? s8 : s4;
                    fb_dt2_o = 1'b1;
                end
            endcase
            dt1_o = comb_o;
        end
    end
endmodule

// File: rtl/plm_flop.sv
module plm_flop
    import plm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clk_term_i,
    input  logic pin_clk_i,
    input  logic use_pin_i,
    input  logic toggle_i,
    input  logic din_i,
    input  logic clr_i,
    input  logic preset_i,
    input  logic ld_en_i,
    input  logic ld_val_i,
    output logic q_o
);
    flop_st_t st_d, st_q;
    logic     src, fire;

    always_comb begin
        src       = use_pin_i ? (clk_term_i & pin_clk_i) : clk_term_i;
        fire      = src & ~st_q.prev;
        st_d.prev = src;
        st_d.q    = st_q.q;
        if (ld_en_i) begin
            st_d.q = ld_val_i;
        end else if (clr_i) begin
            st_d.q = 1'b0;
        end else if (fire) begin
            if (preset_i)      st_d.q = 1'b1;
            else if (toggle_i) st_d.q = st_q.q ^ din_i;
            else               st_d.q = din_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.q;
endmodule

// File: rtl/plm_macrocell.sv
module plm_macrocell
    import plm_pkg::*;
#(
    parameter int GRP_W = 4,
    localparam int PT_W = NUM_GRP * GRP_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PT_W-1:0] pt_sum_i,
    input  logic            pt_clr1_i,
    input  logic            pt_clk1_i,
    input  logic            pt_clk2_i,
    input  logic            pt_clr2_i,
    input  logic            pt_oe_i,
    input  logic            grp_preset_i,
    input  logic            pin_clk_i,
    input  logic            pad_i,
    input  logic [7:0]      cfg_i,
    input  logic            preload_en_i,
    input  logic [1:0]      preload_val_i,
    output logic            pad_o,
    output logic            oe_o,
    output logic [5:0]      fb_o
);
    cfg_t cfg;
    assign cfg = cfg_t'(cfg_i);

    logic dt1, dt2, comb_v, fb_dt2, r2_tog;

    plm_steer #(.GRP_W(GRP_W)) u_steer (
        .pt_i    (pt_sum_i),
        .cfg_i   (cfg),
        .dt1_o   (dt1),
        .dt2_o   (dt2),
        .comb_o  (comb_v),
        .fb_dt2_o(fb_dt2),
        .r2_tog_o(r2_tog)
    );

    logic [NUM_REG-1:0] ck_term, clr_term, use_pin, tog, din, flop_q;
    assign ck_term  = {pt_clk2_i, pt_clk1_i};
    assign clr_term = {pt_clr2_i, pt_clr1_i};
    assign use_pin  = {cfg.clk2_pin, cfg.clk1_pin};
    assign tog      = {r2_tog, cfg.r1_toggle};
    assign din      = {dt2, dt1};

    for (genvar i = 0; i < NUM_REG; i++) begin : g_reg
        plm_flop u_flop (
            .clk       (clk),
            .rst_n     (rst_n),
            .clk_term_i(ck_term[i]),
            .pin_clk_i (pin_clk_i),
            .use_pin_i (use_pin[i]),
            .toggle_i  (tog[i]),
            .din_i     (din[i]),
            .clr_i     (clr_term[i]),
            .preset_i  (grp_preset_i),
            .ld_en_i   (preload_en_i),
            .ld_val_i  (preload_val_i[i]),
            .q_o       (flop_q[i])
        );
    end

    logic out_v, f2;
    assign out_v = cfg.comb_out ? comb_v : flop_q[0];
    assign pad_o = cfg.act_high ? out_v : ~out_v;
    assign oe_o  = pt_oe_i;
    assign f2    = fb_dt2 ? dt2 : flop_q[1];
    assign fb_o  = {f2, ~f2, flop_q[0], ~flop_q[0], pad_i, ~pad_i};
endmodule

// File: rtl/plm_macrocell_chk.sv
module plm_macrocell_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] cfg_i,
    input logic       pt_clk1_i,
    input logic       pin_clk_i,
    input logic       pt_clr1_i,
    input logic       grp_preset_i,
    input logic       preload_en_i,
    input logic [1:0] preload_val_i,
    input logic       dt1,
    input logic       q2,
    input logic [5:0] fb_o
);
    logic src1;
    assign src1 = cfg_i[6] ? (pt_clk1_i & pin_clk_i) : pt_clk1_i;

    // R10
    preload_q1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preload_en_i |=> fb_o[3] == $past(preload_val_i[0]));

    // R10
    preload_q2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preload_en_i |=> q2 == $past(preload_val_i[1]));

    // R8
    clear_q1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !preload_en_i && pt_clr1_i |=> !fb_o[3]);

    // R7
    no_edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !preload_en_i && !pt_clr1_i && !src1 |=> $stable(fb_o[3]));

    // R9
    preset_q1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !preload_en_i && !pt_clr1_i && grp_preset_i && src1 && !$past(src1)
        |=> fb_o[3]);

    // R6
    toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !preload_en_i && !pt_clr1_i && !grp_preset_i && cfg_i[4] && !dt1
        |=> $stable(fb_o[3]));
endmodule

bind plm_macrocell plm_macrocell_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_i        (cfg_i),
    .pt_clk1_i    (pt_clk1_i),
    .pin_clk_i    (pin_clk_i),
    .pt_clr1_i    (pt_clr1_i),
    .grp_preset_i (grp_preset_i),
    .preload_en_i (preload_en_i),
    .preload_val_i(preload_val_i),
    .dt1          (dt1),
    .q2           (flop_q[1]),
    .fb_o         (fb_o)
);

// File: tb/sim_plm_macrocell.sv
module sim_plm_macrocell;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] pt_sum = '0;
    logic        clr1 = 0, ck1 = 0, ck2 = 0, clr2 = 0, oe = 0;
    logic        preset = 0, pin = 0, pad = 0, ld = 0;
    logic [7:0]  cfg = '0;
    logic [1:0]  ldv = '0;
    logic        pad_o, oe_o;
    logic [5:0]  fb_o;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    logic m_q1 = 0, m_q2 = 0, m_p1 = 0, m_p2 = 0;

    always #10 clk = ~clk;

    plm_macrocell u0 (
        .clk(clk), .rst_n(rst_n), .pt_sum_i(pt_sum),
        .pt_clr1_i(clr1), .pt_clk1_i(ck1), .pt_clk2_i(ck2), .pt_clr2_i(clr2),
        .pt_oe_i(oe), .grp_preset_i(preset), .pin_clk_i(pin), .pad_i(pad),
        .cfg_i(cfg), .preload_en_i(ld), .preload_val_i(ldv),
        .pad_o(pad_o), .oe_o(oe_o), .fb_o(fb_o)
    );

    // returns {comb, dt1, dt2, f2_from_dt2}
    function automatic logic [3:0] ref_steer(input logic [7:0] c, input logic [11:0] p);
        logic a, b, d, lo2, all3, cmb, f;
        a = |p[3:0]; b = |p[7:4]; d = |p[11:8];
        lo2 = a | b; all3 = lo2 | d;
        f = 1'b0;
        if (c[2] == 1'b0) begin
            cmb = (c[1:0] == 2'b10) ? all3 : lo2;
            f = (c[1:0] == 2'b11);
        end else if (c[1:0] == 2'b00) cmb = lo2;
        else if (c[1:0] == 2'b10) cmb = all3;
        else if (c[1:0] == 2'b01) begin cmb = a; f = c[5]; end
        else begin cmb = c[5] ? lo2 : a; f = 1'b1; end
        return {cmb, cmb, d, f};
    endfunction

    function automatic logic next_q(input logic q, input logic prv, input logic term,
                                    input logic gate, input logic t, input logic din,
                                    input logic clr, input logic ldn, input logic ldval);
        logic s;
        s = gate ? (term & pin) : term;
        if (ldn) return ldval;
        if (clr) return 1'b0;
        if (!(s && !prv)) return q;
        if (preset) return 1'b1;
        return t ? (q ^ din) : din;
    endfunction

    task automatic model_edge();
        logic [3:0] st;
        logic n1, n2;
        st = ref_steer(cfg, pt_sum);
        if (!rst_n) begin
            m_q1 = 0; m_q2 = 0; m_p1 = 0; m_p2 = 0;
        end else begin
            n1 = next_q(m_q1, m_p1, ck1, cfg[6], cfg[4], st[2], clr1, ld, ldv[0]);
            n2 = next_q(m_q2, m_p2, ck2, cfg[7], cfg[5] & ~cfg[2], st[1], clr2, ld, ldv[1]);
            m_p1 = cfg[6] ? (ck1 & pin) : ck1;
            m_p2 = cfg[7] ? (ck2 & pin) : ck2;
            m_q1 = n1; m_q2 = n2;
        end
    endtask

    task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b (cfg=%b)", req, act, exp, cfg);
        end
    endtask

    task automatic compare_all();
        logic [3:0] st;
        logic v, f2;
        st = ref_steer(cfg, pt_sum);
        v  = cfg[2] ? st[3] : m_q1;
        f2 = st[0] ? st[1] : m_q2;
        // R5 polarity, R2/R3 steering
        chk(!cfg[3] ? "R5" : (cfg[2] ? "R3" : "R2"), {5'b0, pad_o}, {5'b0, cfg[3] ? v : ~v});
        // R11 enable and low feedback bits
        chk("R11", {1'b0, oe_o, fb_o[3:0]}, {1'b0, oe, m_q1, ~m_q1, pad, ~pad});
        // R4 F2 selection
        chk("R4", {4'b0, fb_o[5:4]}, {4'b0, f2, ~f2});
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #3_000_000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        // R1 reset state
        pad = 1;
        cyc(); cyc();
        chk("R1", {4'b0, fb_o[3:2]}, 6'b000001);
        @(negedge clk); rst_n = 1'b1;
        cyc();

        // R6 toggle register 1
        cfg = 8'b0001_0000; pt_sum = 12'h001;
        ck1 = 1; cyc();
        chk("R6", {5'b0, fb_o[3]}, 6'd1);
        ck1 = 0; cyc();
        ck1 = 1; cyc();
        chk("R6", {5'b0, fb_o[3]}, 6'd0);
        ck1 = 0; pt_sum = 12'h000; cyc(); ck1 = 1; cyc();
        chk("R6", {5'b0, fb_o[3]}, 6'd0);
        ck1 = 0; cyc();

        // R7 pin clock gating
        cfg = 8'b0100_0000; pt_sum = 12'h001;
        ck1 = 1; pin = 0; cyc();
        chk("R7", {5'b0, fb_o[3]}, 6'd0);
        pin = 1; cyc();
        chk("R7", {5'b0, fb_o[3]}, 6'd1);
        ck1 = 0; pin = 0; cyc();

        // R8 clear beats preset and edge
        clr1 = 1; preset = 1; ck1 = 1; pin = 1; cyc();
        chk("R8", {5'b0, fb_o[3]}, 6'd0);
        clr1 = 0; preset = 0; ck1 = 0; pin = 0; cyc();

        // R9 preset on edge
        cfg = 8'h00; pt_sum = 12'h000; preset = 1; ck1 = 1; cyc();
        chk("R9", {5'b0, fb_o[3]}, 6'd1);
        preset = 0; ck1 = 0; cyc();

        // R10 preload
        ld = 1; ldv = 2'b10; clr1 = 1; cyc();
        chk("R10", {4'b0, fb_o[5], fb_o[3]}, 6'b000010);
        ld = 0; clr1 = 0; cyc();

        // Sweep every configuration under random terms
        for (int c = 0; c < 256; c++) begin
            cfg = c[7:0];
            for (int k = 0; k < 40; k++) begin
                pt_sum = 12'($urandom);
                ck1    = 1'($urandom);
                ck2    = 1'($urandom);
                pin    = 1'($urandom);
                pad    = 1'($urandom);
                oe     = 1'($urandom);
                clr1   = ($urandom % 8) == 0;
                clr2   = ($urandom % 8) == 0;
                preset = ($urandom % 4) == 0;
                ld     = ($urandom % 16) == 0;
                ldv    = 2'($urandom);
                cyc();
            end
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule